// File: doc/BRIEF.md
# Shared Address Match Table with Per-Entry Port Masks

This block keeps a table of Ethernet station addresses that software programs one byte at a time. Each entry carries a port membership mask, so one address can belong to several ports and one port can own several addresses. Each entry also carries a separate valid bit. The block does not clear its address storage at reset. Instead every valid bit resets to zero, so no entry takes part in a comparison until software marks it valid.

Address bytes are not given an explicit byte offset. Each entry keeps a small byte pointer in the top three bits of its 16-bit mask register. Every address byte read or write on that entry uses the byte the pointer selects and then advances the pointer. Writing to the mask register puts the pointer back to the least significant byte. Software therefore writes the mask and then issues six address byte writes.

Frame-side logic presents the frame's receive port and a 48-bit address. It pulses a strobe once the destination address has been buffered, and pulses a second strobe once the source address has been buffered. For each strobe the block searches every valid entry whose mask includes the receive port, and reports a hit for that address kind. A small sequencer enforces the order: destination first, then source. The sequencer has two states:
- `SEQ_WAIT_DA` waits for a destination strobe.
- `SEQ_WAIT_SA` waits for a source strobe.

Its transitions are:
- T_DA_SEEN: `SEQ_WAIT_DA` → `SEQ_WAIT_SA` on a destination strobe.
- T_DA_RESTART: `SEQ_WAIT_SA` → `SEQ_WAIT_SA` on a destination strobe, which starts a new frame.
- T_SA_SEEN: `SEQ_WAIT_SA` → `SEQ_WAIT_DA` on a source strobe without a destination strobe.
- T_SA_EARLY: `SEQ_WAIT_DA` → `SEQ_WAIT_DA` on a lone source strobe, which is ignored.

Top module: `shared_addr_cam`

## Requirements
- R1: After reset the outputs and registers hold these values:
  - `da_hit`, `sa_hit`, `da_done`, `sa_done` and `cfg_rdata` are 0.
  - Every mask is 0 and every valid bit is 0.
  - Every byte pointer is 1, so a mask-high read returns 8'h20.
  - No comparison hits.
- R2: `cfg_sel` selects the register:
  - 0 is the address byte.
  - 1 is the mask low byte, which is mask bits 7:0.
  - 2 is the mask high byte, which reads as {pointer[2:0], mask[12:8]}.
  - 3 is a validation group.

  An address byte write to entry `cfg_entry` stores `cfg_wdata` in the byte the entry's pointer selects and then increments the pointer. Pointer value k selects address bits 8k-1:8k-8, so 1 is the least significant byte. Six writes program a full address.
- R3: An address byte read returns the selected byte and advances the pointer exactly as a write does. After byte 6 the pointer wraps to 1.
- R4: A write to either mask byte resets that entry's pointer to 1. The pointer bits of a mask-high write are discarded.
- R5: Validation group g is selected by `cfg_entry[1:0]` when `cfg_sel`=3. Bit i of group g is the valid bit of entry 8g+i.
- R6: A `da_strobe` sampled at a clock edge makes `da_done` high for the following cycle. In that same cycle `da_hit` is 1 exactly when some entry matches. An entry matches when it is valid, its 48-bit address equals `frm_addr`, and its mask bit for `frm_port` is set.
- R7: An entry does not match if any of these holds:
  - its valid bit is clear;
  - its mask bit for the receive port is clear;
  - the receive port is 13 or above.
- R8: A `sa_strobe` is accepted only after a destination compare.
  - When accepted, `sa_done` and `sa_hit` follow R6's timing and match rule, and the sequencer returns to waiting for a destination.
  - A lone `sa_strobe` while the sequencer waits for a destination produces no `sa_done` and leaves `sa_hit` unchanged.
- R9: A `da_strobe` while the sequencer waits for a source address restarts the frame. It produces a fresh destination result and still waits for a source. When both strobes arrive together, only the destination is handled.
- R10: `da_hit` and `sa_hit` hold their values until the next compare of their own kind. The `_done` outputs are single-cycle pulses.
- R11: Read data appears on `cfg_rdata` one cycle after `cfg_rd` and holds otherwise. When `cfg_wr` and `cfg_rd` are both high, the write takes effect and no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register byte write |
| cfg_rd | input | 1 | Register byte read |
| cfg_sel | input | 2 | Register select: address byte, mask low, mask high, validation group |
| cfg_entry | input | 5 | Entry index (low bits pick the validation group) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| frm_port | input | 4 | Receive port of the current frame |
| frm_addr | input | 48 | Buffered address to compare |
| da_strobe | input | 1 | Destination address fully buffered |
| sa_strobe | input | 1 | Source address fully buffered |
| da_done | output | 1 | Destination compare result valid |
| da_hit | output | 1 | Destination address matched |
| sa_done | output | 1 | Source compare result valid |
| sa_hit | output | 1 | Source address matched |

## Verification
The bench uses the default parameters:
- 32 entries, so all four validation groups exist and the last entry (index 31, the top bit of group 3) is reachable.
- 13 ports in a 4-bit port field, so port indices 13 to 15 are reachable and can be checked for rejection.
- Six address bytes, so the pointer wrap after the sixth access is exercised by both reads and writes.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int PTR_W  = 3;
    localparam int MASK_W = REG_W - PTR_W;

    typedef enum logic [1:0] {
        SEL_ADDR    = 2'd0,
        SEL_MASK_LO = 2'd1,
        SEL_MASK_HI = 2'd2,
        SEL_VALID   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        SEQ_WAIT_DA = 1'b0,
        SEQ_WAIT_SA = 1'b1
    } seq_state_e;
endpackage

// File: rtl/cam_regs.sv
module cam_regs
    import cam_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int ADDR_BYTES = 6,
    localparam int ENTRY_W   = $clog2(ENTRIES),
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic                              cfg_rd,
    input  logic [1:0]                        cfg_sel,
    input  logic [ENTRY_W-1:0]                cfg_entry,
    input  logic [BYTE_W-1:0]                 cfg_wdata,
    output logic [BYTE_W-1:0]                 cfg_rdata,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    addr_q,
    output logic [ENTRIES-1:0][MASK_W-1:0]    mask_q,
    output logic [ENTRIES-1:0][PTR_W-1:0]     ptr_q,
    output logic [ENTRIES-1:0]                valid_q
);
    localparam int GROUPS = ENTRIES / BYTE_W;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int HI_W   = MASK_W - BYTE_W;

    cfg_sel_e sel;
    logic     acc_addr;
    logic     wr_addr;
    logic     wr_mlo;
    logic     wr_mhi;
    logic     wr_valid;
    logic     rd_ok;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign rd_ok    = cfg_rd && !cfg_wr;
    assign wr_addr  = cfg_wr && (sel == SEL_ADDR);
    assign acc_addr = wr_addr || (rd_ok && (sel == SEL_ADDR));
    assign wr_mlo   = cfg_wr && (sel == SEL_MASK_LO);
    assign wr_mhi   = cfg_wr && (sel == SEL_MASK_HI);
    assign wr_valid = cfg_wr && (sel == SEL_VALID);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic              here;
        logic [ADDR_W-1:0] a_r;
        logic [MASK_W-1:0] m_r;
        logic [PTR_W-1:0]  p_r;

        assign here = (cfg_entry == ENTRY_W'(e));

        // address storage has no reset; valid bits gate its use
        always_ff @(posedge clk) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (wr_addr && here && (p_r == PTR_W'(b + 1))) begin
                    a_r[b*BYTE_W +: BYTE_W] <= cfg_wdata;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_r <= '0;
                p_r <= PTR_W'(1);
            end else if (here) begin
                if (wr_mlo) begin
                    m_r[BYTE_W-1:0] <= cfg_wdata;
                    p_r             <= PTR_W'(1);
                end else if (wr_mhi) begin
                    m_r[MASK_W-1:BYTE_W] <= cfg_wdata[HI_W-1:0];
                    p_r                  <= PTR_W'(1);
                end else if (acc_addr) begin
                    p_r <= (p_r == PTR_W'(ADDR_BYTES)) ? PTR_W'(1) : p_r + PTR_W'(1);
                end
            end
        end

        assign addr_q[e] = a_r;
        assign mask_q[e] = m_r;
        assign ptr_q[e]  = p_r;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_valid && (cfg_entry[GRP_W-1:0] == GRP_W'(g))) begin
                valid_q[g*BYTE_W +: BYTE_W] <= cfg_wdata;
            end
        end
    end

    logic [ADDR_W-1:0] a_sel;
    logic [MASK_W-1:0] m_sel;
    logic [PTR_W-1:0]  p_sel;
    logic [BYTE_W-1:0] byte_sel;
    logic [BYTE_W-1:0] grp_sel;
    logic [BYTE_W-1:0] rd_val;

    assign a_sel = addr_q[cfg_entry];
    assign m_sel = mask_q[cfg_entry];
    assign p_sel = ptr_q[cfg_entry];

    always_comb begin
        byte_sel = '0;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (p_sel == PTR_W'(b + 1)) begin
                byte_sel = a_sel[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        grp_sel = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (cfg_entry[GRP_W-1:0] == GRP_W'(g)) begin
                grp_sel = valid_q[g*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR:    rd_val = byte_sel;
            SEL_MASK_LO: rd_val = m_sel[BYTE_W-1:0];
            SEL_MASK_HI: rd_val = {p_sel, m_sel[MASK_W-1:BYTE_W]};
            SEL_VALID:   rd_val = grp_sel;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (rd_ok) begin
            cfg_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/cam_match.sv
module cam_match
    import cam_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int PORTS      = 13,
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
    localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q,
    input  logic [ENTRIES-1:0][MASK_W-1:0] mask_q,
    input  logic [ENTRIES-1:0]             valid_q,
    input  logic [ADDR_W-1:0]              key,
    input  logic [PORT_W-1:0]              port,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic                           any_hit
);
    localparam logic [PORT_W:0] PORT_LIM = (PORT_W + 1)'(PORTS);

    logic port_ok;
    assign port_ok = ({1'b0, port} < PORT_LIM);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [MASK_W-1:0] shifted;
        assign shifted    = mask_q[e] >> port;
        assign hit_vec[e] = valid_q[e] && port_ok && shifted[0] && (addr_q[e] == key);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/cam_seq.sv
module cam_seq
    import cam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       da_strobe,
    input  logic       sa_strobe,
    input  logic       any_hit,
    output seq_state_e state,
    output logic       da_done,
    output logic       da_hit,
    output logic       sa_done,
    output logic       sa_hit
);
    seq_state_e state_nx;
    logic       take_da;
    logic       take_sa;

    always_comb begin
        state_nx = state;
        take_da  = 1'b0;
        take_sa  = 1'b0;
        unique case (state)
            SEQ_WAIT_DA: begin
                if (da_strobe) begin          // T_DA_SEEN
                    take_da  = 1'b1;
                    state_nx = SEQ_WAIT_SA;
                end                           // T_SA_EARLY otherwise
            end
            SEQ_WAIT_SA: begin
                if (da_strobe) begin          // T_DA_RESTART
                    take_da  = 1'b1;
                    state_nx = SEQ_WAIT_SA;
                end else if (sa_strobe) begin // T_SA_SEEN
                    take_sa  = 1'b1;
                    state_nx = SEQ_WAIT_DA;
                end
            end
            default: state_nx = SEQ_WAIT_DA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_WAIT_DA;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            da_done <= 1'b0;
            da_hit  <= 1'b0;
            sa_done <= 1'b0;
            sa_hit  <= 1'b0;
        end else begin
            da_done <= take_da;
            sa_done <= take_sa;
            if (take_da) da_hit <= any_hit;
            if (take_sa) sa_hit <= any_hit;
        end
    end
endmodule

// File: rtl/shared_addr_cam.sv
module shared_addr_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int PORTS      = 13,
    parameter int ADDR_BYTES = 6,
    localparam int ENTRY_W   = $clog2(ENTRIES),
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
    localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [1:0]         cfg_sel,
    input  logic [ENTRY_W-1:0] cfg_entry,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    input  logic [PORT_W-1:0]  frm_port,
    input  logic [ADDR_W-1:0]  frm_addr,
    input  logic               da_strobe,
    input  logic               sa_strobe,
    output logic               da_done,
    output logic               da_hit,
    output logic               sa_done,
    output logic               sa_hit
);
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_w;
    logic [ENTRIES-1:0][MASK_W-1:0] mask_w;
    logic [ENTRIES-1:0][PTR_W-1:0]  ptr_w;
    logic [ENTRIES-1:0]             valid_w;
    logic [ENTRIES-1:0]             hit_vec_w;
    logic                           any_hit_w;
    seq_state_e                     state_w;

    cam_regs #(
        .ENTRIES   (ENTRIES),
        .ADDR_BYTES(ADDR_BYTES)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_rd   (cfg_rd),
        .cfg_sel  (cfg_sel),
        .cfg_entry(cfg_entry),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .addr_q   (addr_w),
        .mask_q   (mask_w),
        .ptr_q    (ptr_w),
        .valid_q  (valid_w)
    );

    cam_match #(
        .ENTRIES   (ENTRIES),
        .PORTS     (PORTS),
        .ADDR_BYTES(ADDR_BYTES)
    ) match_i (
        .addr_q (addr_w),
        .mask_q (mask_w),
        .valid_q(valid_w),
        .key    (frm_addr),
        .port   (frm_port),
        .hit_vec(hit_vec_w),
        .any_hit(any_hit_w)
    );

    cam_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .da_strobe(da_strobe),
        .sa_strobe(sa_strobe),
        .any_hit  (any_hit_w),
        .state    (state_w),
        .da_done  (da_done),
        .da_hit   (da_hit),
        .sa_done  (sa_done),
        .sa_hit   (sa_hit)
    );
endmodule

// File: rtl/cam_checker.sv
module cam_checker
    import cam_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int PORTS      = 13,
    parameter int ADDR_BYTES = 6,
    localparam int ENTRY_W   = $clog2(ENTRIES),
    localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr,
    input logic [1:0]                    cfg_sel,
    input logic [ENTRY_W-1:0]            cfg_entry,
    input logic [PORT_W-1:0]             frm_port,
    input logic                          da_strobe,
    input logic                          da_done,
    input logic                          da_hit,
    input logic                          sa_done,
    input logic                          sa_hit,
    input logic [ENTRIES-1:0]            valid,
    input logic [ENTRIES-1:0][PTR_W-1:0] ptrs
);
    localparam logic [PORT_W:0] PORT_LIM = (PORT_W + 1)'(PORTS);

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (da_done) armed_q <= 1'b1;
        else if (sa_done) armed_q <= 1'b0;
    end

    AST_DA_DONE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        da_done |-> $past(da_strobe)); // R6
    AST_SA_AFTER_DA: assert property (@(posedge clk) disable iff (!rst_n)
        sa_done |-> armed_q); // R8
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({da_done, sa_done})); // R9
    AST_DA_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !da_done |-> $stable(da_hit)); // R10
    AST_SA_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sa_done |-> $stable(sa_hit)); // R10
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (da_done && da_hit) |-> ($past(valid) != '0)); // R7
    AST_BAD_PORT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (da_done && ({1'b0, $past(frm_port)} >= PORT_LIM)) |-> !da_hit); // R7

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ptr
        AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (ptrs[e] >= PTR_W'(1)) && (ptrs[e] <= PTR_W'(ADDR_BYTES))); // R3
        AST_MASK_WR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_wr && (cfg_sel == SEL_MASK_LO || cfg_sel == SEL_MASK_HI)
                  && cfg_entry == ENTRY_W'(e)) |-> (ptrs[e] == PTR_W'(1))); // R4
    end
endmodule

bind shared_addr_cam cam_checker #(
    .ENTRIES   (ENTRIES),
    .PORTS     (PORTS),
    .ADDR_BYTES(ADDR_BYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_entry(cfg_entry),
    .frm_port (frm_port),
    .da_strobe(da_strobe),
    .da_done  (da_done),
    .da_hit   (da_hit),
    .sa_done  (sa_done),
    .sa_hit   (sa_hit),
    .valid    (valid_w),
    .ptrs     (ptr_w)
);

// File: tb/shared_addr_cam_tb_top.sv
module shared_addr_cam_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [4:0]  cfg_entry = 5'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  frm_port = 4'd0;
    logic [47:0] frm_addr = 48'd0;
    logic        da_strobe = 1'b0;
    logic        sa_strobe = 1'b0;
    logic        da_done, da_hit, sa_done, sa_hit;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] ADDR_A = 48'h0A0B0C0D0E0F;
    localparam logic [47:0] ADDR_B = 48'h112233445566;
    localparam logic [47:0] ADDR_C = 48'hDEADBEEF0001;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_addr_cam dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_sel(cfg_sel), .cfg_entry(cfg_entry), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .frm_port(frm_port), .frm_addr(frm_addr),
        .da_strobe(da_strobe), .sa_strobe(sa_strobe), .da_done(da_done),
        .da_hit(da_hit), .sa_done(sa_done), .sa_hit(sa_hit)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [4:0] e, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_entry = e; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] s, input logic [4:0] e, output logic [7:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_sel = s; cfg_entry = e;
        @(negedge clk);
        d = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic program_entry(input logic [4:0] e, input logic [47:0] a, input logic [12:0] m);
        cfg_write(2'd1, e, m[7:0]);
        cfg_write(2'd2, e, {3'b000, m[12:8]});
        for (int b = 0; b < 6; b++) cfg_write(2'd0, e, a[b*8 +: 8]);
    endtask

    // drives one strobe for one cycle, samples the registered result after the edge
    task automatic compare(input bit is_sa, input bit both, input logic [3:0] p,
                           input logic [47:0] a, output logic done_d, output logic hit_d,
                           output logic done_s, output logic hit_s);
        @(negedge clk);
        frm_port = p; frm_addr = a;
        da_strobe = !is_sa || both;
        sa_strobe = is_sa || both;
        @(negedge clk);
        done_d = da_done; hit_d = da_hit; done_s = sa_done; hit_s = sa_hit;
        da_strobe = 1'b0; sa_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1", "da_hit", da_hit, 0);
        chk("R1", "sa_hit", sa_hit, 0);
        chk("R1", "da_done", da_done, 0);
        chk("R1", "sa_done", sa_done, 0);
        chk("R1", "rdata", cfg_rdata, 0);
        cfg_read(2'd2, 5'd9, d);
        chk("R1", "mask hi/ptr entry 9", d, 8'h20);
        cfg_read(2'd1, 5'd31, d);
        chk("R1", "mask lo entry 31", d, 8'h00);
        for (int g = 0; g < 4; g++) begin
            cfg_read(2'd3, 5'(g), d);
            chk("R1", "valid group", d, 8'h00);
        end
    endtask

    task automatic t_bytes();
        logic [7:0] d;
        program_entry(5'd5, ADDR_A, 13'h0008);
        cfg_read(2'd2, 5'd5, d);
        chk("R3", "pointer back to 1 after six writes", d, 8'h20);
        for (int b = 0; b < 6; b++) begin
            cfg_read(2'd0, 5'd5, d);
            chk("R2", "address byte readback", d, ADDR_A[b*8 +: 8]);
        end
        cfg_read(2'd0, 5'd5, d);
        chk("R3", "read wraps to least significant byte", d, 8'h0F);
        cfg_read(2'd2, 5'd5, d);
        chk("R3", "pointer 2 after wrap read", d, 8'h40);
    endtask

    task automatic t_mask_ptr();
        logic [7:0] d;
        cfg_write(2'd0, 5'd7, 8'h99);
        cfg_write(2'd0, 5'd7, 8'h98);
        cfg_read(2'd2, 5'd7, d);
        chk("R2", "pointer 3 after two writes", d, 8'h60);
        cfg_write(2'd1, 5'd7, 8'h00);
        cfg_read(2'd2, 5'd7, d);
        chk("R4", "mask lo write resets pointer", d, 8'h20);
        cfg_write(2'd0, 5'd7, 8'h11);
        cfg_write(2'd2, 5'd7, 8'hFF);
        cfg_read(2'd2, 5'd7, d);
        chk("R4", "mask hi write keeps pointer 1", d, 8'h3F);
        cfg_read(2'd0, 5'd7, d);
        chk("R2", "first byte holds latest lsb write", d, 8'h11);
    endtask

    task automatic t_valid();
        logic [7:0] d;
        cfg_write(2'd3, 5'd2, 8'hA5);
        cfg_read(2'd3, 5'd2, d);
        chk("R5", "group 2 readback", d, 8'hA5);
        cfg_read(2'd3, 5'd0, d);
        chk("R5", "group 0 untouched", d, 8'h00);
        cfg_read(2'd3, 5'd30, d);
        chk("R5", "entry index 30 selects group 2", d, 8'hA5);
        cfg_write(2'd3, 5'd2, 8'h00);
    endtask

    task automatic t_match();
        logic dd, dh, sd, sh;
        program_entry(5'd20, ADDR_B, 13'h1000);
        program_entry(5'd31, ADDR_C, 13'h1FFF);
        compare(0, 0, 4'd3, ADDR_A, dd, dh, sd, sh);
        chk("R7", "no valid bits, no hit", {dd, dh}, 2'b10);
        cfg_write(2'd3, 5'd0, 8'h20);  // entry 5
        cfg_write(2'd3, 5'd2, 8'h10);  // entry 20
        cfg_write(2'd3, 5'd3, 8'h80);  // entry 31
        compare(0, 0, 4'd3, ADDR_A, dd, dh, sd, sh);
        chk("R6", "DA hit entry 5 port 3", {dd, dh, sd}, 3'b110);
        compare(1, 0, 4'd3, ADDR_B, dd, dh, sd, sh);
        chk("R8", "SA miss by mask", {dd, sd, sh}, 3'b010);
        chk("R7", "DA result held during SA", dh, 1'b1);
        compare(0, 0, 4'd12, ADDR_B, dd, dh, sd, sh);
        chk("R6", "DA hit entry 20 top port", {dd, dh}, 2'b11);
        compare(1, 0, 4'd12, ADDR_C, dd, dh, sd, sh);
        chk("R8", "SA hit entry 31", {dd, sd, sh}, 3'b011);
        compare(0, 0, 4'd4, ADDR_A, dd, dh, sd, sh);
        chk("R7", "mask bit clear port 4", {dd, dh}, 2'b10);
        compare(0, 0, 4'd13, ADDR_C, dd, dh, sd, sh);
        chk("R7", "port 13 rejected", {dd, dh}, 2'b10);
        compare(0, 0, 4'd15, ADDR_C, dd, dh, sd, sh);
        chk("R7", "port 15 rejected", {dd, dh}, 2'b10);
        compare(0, 0, 4'd0, ADDR_C, dd, dh, sd, sh);
        chk("R6", "port 0 hit entry 31", {dd, dh}, 2'b11);
        compare(0, 0, 4'd0, ADDR_C ^ 48'h800000000000, dd, dh, sd, sh);
        chk("R6", "top-bit address difference misses", {dd, dh}, 2'b10);
        cfg_write(2'd3, 5'd0, 8'h00);
        compare(0, 0, 4'd3, ADDR_A, dd, dh, sd, sh);
        chk("R7", "invalidated entry 5 misses", {dd, dh}, 2'b10);
        compare(1, 0, 4'd0, ADDR_C, dd, dh, sd, sh);
        chk("R8", "SA closes frame with hit", {sd, sh}, 2'b11);
    endtask

    task automatic t_sa_ignored();
        logic dd, dh, sd, sh;
        compare(1, 0, 4'd0, 48'h0, dd, dh, sd, sh);
        chk("R8", "lone SA ignored, sa_hit kept", {dd, sd, sh}, 3'b001);
        compare(0, 0, 4'd12, ADDR_B, dd, dh, sd, sh);
        chk("R8", "DA accepted after ignored SA", {dd, dh}, 2'b11);
        compare(1, 0, 4'd12, ADDR_A, dd, dh, sd, sh);
        chk("R8", "SA miss accepted", {sd, sh}, 2'b10);
    endtask

    task automatic t_restart();
        logic dd, dh, sd, sh;
        compare(0, 0, 4'd12, ADDR_B, dd, dh, sd, sh);
        chk("R9", "first DA hit", {dd, dh}, 2'b11);
        compare(0, 0, 4'd12, ADDR_A, dd, dh, sd, sh);
        chk("R9", "restart DA gives fresh miss", {dd, dh, sd}, 3'b100);
        compare(0, 1, 4'd12, ADDR_B, dd, dh, sd, sh);
        chk("R9", "both strobes: DA only", {dd, dh, sd, sh}, 4'b1100);
        compare(1, 0, 4'd12, ADDR_C, dd, dh, sd, sh);
        chk("R9", "SA still awaited after restart", {sd, sh}, 2'b11);
        repeat (3) @(negedge clk);
        chk("R10", "hits held, done low", {da_done, da_hit, sa_done, sa_hit}, 4'b0101);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        cfg_read(2'd1, 5'd5, d);
        chk("R11", "mask lo entry 5", d, 8'h08);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_sel = 2'd1; cfg_entry = 5'd20; cfg_wdata = 8'h3C;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        chk("R11", "no read on collision, rdata held", cfg_rdata, 8'h08);
        repeat (2) @(negedge clk);
        chk("R11", "rdata holds when idle", cfg_rdata, 8'h08);
        cfg_read(2'd1, 5'd20, d);
        chk("R11", "write took effect", d, 8'h3C);
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_mask_ptr();
        t_valid();
        t_match();
        t_sa_ignored();
        t_restart();
        t_collision();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule